// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Controller

This block resolves and acknowledges interrupts for two chained 8-line priority units. The upper unit (the "master") talks to the CPU; the lower unit (the "slave") presents its request on master line 2. Each of the 16 raw interrupt inputs is synchronised and edge-detected, and each transition updates a per-line request bit. A per-line trigger-mode register decides whether an acknowledge clears that request bit (edge mode) or leaves it alone (level mode).

When the acknowledge strobe arrives while the CPU interrupt line is high, the master's winning line is taken. If that line is the cascade input, the slave's winner is acknowledged in the same cycle. One cycle later a vector is returned. Its upper bits come from the programmed base of the unit that owns the line, and its low three bits are the line number within that unit. Each acknowledged line either enters the in-service set or, with automatic end-of-interrupt enabled, is retired at once. In the second case it can optionally rotate the priority so that the line just served becomes lowest.

Top module: `casc_int_ack`

## Requirements
- R1: After reset `int_o` and `vec_valid_o` are low and both units' trigger-mode readbacks are 0. Internally the master holds only its cascade line (bit 2) as level-triggered.
- R2: A raw input rising edge sets its request bit three clock edges after the input changes, and a falling edge clears it after the same delay. `int_o` follows combinationally from the request and in-service state.
- R3: Priority starts with line 0 highest and line 7 lowest in each unit. With a rotation offset p, the order becomes p, p+1, … modulo 8.
- R4: On acknowledge, the winning line's request bit is cleared if its trigger bit is 0 (edge). It is kept if the bit is 1 (level), so a level line that stays high interrupts again.
- R5: With `aeoi_i` low, an acknowledged line enters the in-service set. From then on it blocks itself and all lower-priority lines, while higher-priority lines still raise `int_o`.
- R6: With `aeoi_i` and `rot_aeoi_i` both high, acknowledging line L sets that unit's rotation offset to (L+1) mod 8.
- R7: When the master winner is line 2, the slave's winner is acknowledged in the same cycle, and the vector reports the slave line.
- R8: The vector is {base[7:3], line[2:0]}. The base is `mst_base_i` for master lines and `slv_base_i` for slave lines.
- R9: A trigger write masks the data with 0xF8 on the master (`trig_sel_i`=0) and 0xDE on the slave (`trig_sel_i`=1). Master bit 2 is always level internally. Readback returns only the writable bits.
- R10: Transitions on raw input 2 have no effect.
- R11: An acknowledge while `int_o` is low produces no `vec_valid_o`.
- R12: An acknowledge while `int_o` is high produces a one-cycle `vec_valid_o` pulse on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 16 | Raw interrupt lines; 0-7 master, 8-15 slave |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| aeoi_i | input | 1 | Automatic end-of-interrupt enable |
| rot_aeoi_i | input | 1 | Rotate on automatic end-of-interrupt |
| mst_base_i | input | 8 | Master vector base (bits 7:3 used) |
| slv_base_i | input | 8 | Slave vector base (bits 7:3 used) |
| trig_we_i | input | 1 | Trigger-mode register write strobe |
| trig_sel_i | input | 1 | Trigger register select: 0 master, 1 slave |
| trig_wdata_i | input | 8 | Trigger-mode write data, 1 = level |
| trig_rdata_o | output | 8 | Masked trigger-mode readback of selected unit |
| int_o | output | 1 | CPU interrupt request |
| vec_o | output | 8 | Acknowledged vector |
| vec_valid_o | output | 1 | Vector valid pulse |

## Verification
On every cycle the assertions check the acknowledge handshake: a vector appears exactly one cycle after an accepted acknowledge and never after an idle one. They also check that the vector's upper bits match one of the two bases, and that readback never exposes a non-writable trigger bit. Which line wins under rotation and in-service blocking, whether edge or level requests are cleared, and whether the slave is pulled through the cascade can only be shown by the bench's scenarios. Its reference model tracks those effects across sequences of acknowledges.

// File: rtl/casc_int_pkg.sv
package casc_int_pkg;
  localparam int unsigned UNIT_LINES = 8;
  localparam int unsigned UNIT_IW    = $clog2(UNIT_LINES);
  localparam logic [UNIT_LINES-1:0] MST_TRIG_MASK_DEF = 8'hF8;
  localparam logic [UNIT_LINES-1:0] SLV_TRIG_MASK_DEF = 8'hDE;
  localparam int unsigned CASC_LINE_DEF = 2;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= raw_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= stage_q[STAGES-1];
  end

  assign rise_o = stage_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pic_prio.sv
// Rotating priority search; LINES must be a power of two.
module pic_prio #(
  parameter int unsigned LINES = 8,
  localparam int unsigned IW   = $clog2(LINES)
) (
  input  logic [LINES-1:0] mask_i,
  input  logic [IW-1:0]    rot_i,
  output logic             found_o,
  output logic [IW-1:0]    rank_o,
  output logic [IW-1:0]    line_o
);
  always_comb begin
    found_o = 1'b0;
    rank_o  = '0;
    line_o  = '0;
    for (int k = LINES-1; k >= 0; k--) begin
      if (mask_i[rot_i + IW'(k)]) begin
        found_o = 1'b1;
        rank_o  = IW'(k);
        line_o  = rot_i + IW'(k);
      end
    end
  end
endmodule

// File: rtl/pic_unit.sv
module pic_unit #(
  parameter int unsigned     LINES      = 8,
  parameter logic [LINES-1:0] TRIG_MASK = '1,
  parameter logic [LINES-1:0] TRIG_FORCE = '0,
  parameter bit              CASC_EN    = 1'b0,
  parameter int unsigned     CASC_LINE  = 2,
  localparam int unsigned    IW         = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] rise_i,
  input  logic [LINES-1:0] fall_i,
  input  logic             casc_i,
  input  logic             ack_i,
  input  logic             aeoi_i,
  input  logic             rot_aeoi_i,
  input  logic             trig_we_i,
  input  logic [LINES-1:0] trig_wdata_i,
  output logic             req_o,
  output logic [IW-1:0]    win_o,
  output logic [LINES-1:0] trig_rd_o
);
  logic [LINES-1:0] irr_q, isr_q, trig_q, irr_eff, irr_d;
  logic [IW-1:0]    rot_q;
  logic             req_found, isr_found;
  logic [IW-1:0]    req_rank, isr_rank, isr_line;

  always_comb begin
    irr_eff = irr_q;
    if (CASC_EN) irr_eff[CASC_LINE] = casc_i;
  end

  pic_prio #(.LINES(LINES)) u_req_prio (
    .mask_i(irr_eff), .rot_i(rot_q),
    .found_o(req_found), .rank_o(req_rank), .line_o(win_o)
  );

  pic_prio #(.LINES(LINES)) u_isr_prio (
    .mask_i(isr_q), .rot_i(rot_q),
    .found_o(isr_found), .rank_o(isr_rank), .line_o(isr_line)
  );

  assign req_o     = req_found && (!isr_found || (req_rank < isr_rank));
  assign trig_rd_o = trig_q & TRIG_MASK;

  // ack clear first, then new transitions win
  always_comb begin
    irr_d = irr_q;
    if (ack_i && !trig_q[win_o]) irr_d[win_o] = 1'b0;
    irr_d = (irr_d | rise_i) & ~fall_i;
    if (CASC_EN) irr_d[CASC_LINE] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      isr_q  <= '0;
      rot_q  <= '0;
      trig_q <= TRIG_FORCE;
    end else begin
      irr_q <= irr_d;
      if (ack_i && !aeoi_i) isr_q[win_o] <= 1'b1;
      if (ack_i && aeoi_i && rot_aeoi_i) rot_q <= win_o + IW'(1);
      if (trig_we_i) trig_q <= (trig_wdata_i & TRIG_MASK) | TRIG_FORCE;
    end
  end
endmodule

// File: rtl/casc_int_ack.sv
module casc_int_ack
  import casc_int_pkg::*;
#(
  parameter int unsigned     LINES         = UNIT_LINES,
  parameter int unsigned     VEC_W         = 8,
  parameter int unsigned     SYNC_STAGES   = 2,
  parameter int unsigned     CASC_LINE     = CASC_LINE_DEF,
  parameter logic [LINES-1:0] MST_TRIG_MASK = MST_TRIG_MASK_DEF,
  parameter logic [LINES-1:0] SLV_TRIG_MASK = SLV_TRIG_MASK_DEF,
  localparam int unsigned    N_IN          = 2 * LINES,
  localparam int unsigned    IW            = $clog2(LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_IN-1:0]    irq_i,
  input  logic               ack_i,
  input  logic               aeoi_i,
  input  logic               rot_aeoi_i,
  input  logic [VEC_W-1:0]   mst_base_i,
  input  logic [VEC_W-1:0]   slv_base_i,
  input  logic               trig_we_i,
  input  logic               trig_sel_i,
  input  logic [LINES-1:0]   trig_wdata_i,
  output logic [LINES-1:0]   trig_rdata_o,
  output logic               int_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_valid_o
);
  localparam logic [LINES-1:0] CASC_BIT  = LINES'(1) << CASC_LINE;
  localparam logic [VEC_W-1:0] BASE_MASK = ~VEC_W'(LINES-1);

  logic [N_IN-1:0]  rise, fall;
  logic [LINES-1:0] m_rise, m_fall, m_rd, s_rd;
  logic             m_req, s_req, take, s_take;
  logic [IW-1:0]    m_win, s_win, line_sel;
  logic [VEC_W-1:0] base_sel, vec_d;

  pic_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .raw_i(irq_i), .rise_o(rise), .fall_o(fall)
  );

  // raw cascade input is not a source
  assign m_rise = rise[LINES-1:0] & ~CASC_BIT;
  assign m_fall = fall[LINES-1:0] & ~CASC_BIT;

  assign take   = ack_i && m_req;
  assign s_take = take && (m_win == IW'(CASC_LINE));

  pic_unit #(
    .LINES(LINES), .TRIG_MASK(MST_TRIG_MASK), .TRIG_FORCE(CASC_BIT),
    .CASC_EN(1'b1), .CASC_LINE(CASC_LINE)
  ) u_mst (
    .clk_i, .rst_ni,
    .rise_i(m_rise), .fall_i(m_fall), .casc_i(s_req),
    .ack_i(take), .aeoi_i, .rot_aeoi_i,
    .trig_we_i(trig_we_i && !trig_sel_i), .trig_wdata_i,
    .req_o(m_req), .win_o(m_win), .trig_rd_o(m_rd)
  );

  pic_unit #(
    .LINES(LINES), .TRIG_MASK(SLV_TRIG_MASK), .TRIG_FORCE('0),
    .CASC_EN(1'b0), .CASC_LINE(CASC_LINE)
  ) u_slv (
    .clk_i, .rst_ni,
    .rise_i(rise[N_IN-1:LINES]), .fall_i(fall[N_IN-1:LINES]), .casc_i(1'b0),
    .ack_i(s_take), .aeoi_i, .rot_aeoi_i,
    .trig_we_i(trig_we_i && trig_sel_i), .trig_wdata_i,
    .req_o(s_req), .win_o(s_win), .trig_rd_o(s_rd)
  );

  assign line_sel     = s_take ? s_win : m_win;
  assign base_sel     = s_take ? slv_base_i : mst_base_i;
  assign vec_d        = (base_sel & BASE_MASK) | VEC_W'(line_sel);
  assign int_o        = m_req;
  assign trig_rdata_o = trig_sel_i ? s_rd : m_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      vec_valid_o <= take;
      if (take) vec_o <= vec_d;
    end
  end
endmodule

// File: rtl/casc_int_ack_chk.sv
module casc_int_ack_chk #(
  parameter int unsigned     LINES         = 8,
  parameter int unsigned     VEC_W         = 8,
  parameter int unsigned     CASC_LINE     = 2,
  parameter logic [LINES-1:0] MST_TRIG_MASK = 8'hF8,
  parameter logic [LINES-1:0] SLV_TRIG_MASK = 8'hDE,
  localparam int unsigned    IW            = $clog2(LINES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ack_i,
  input logic             int_o,
  input logic             vec_valid_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [VEC_W-1:0] mst_base_i,
  input logic [VEC_W-1:0] slv_base_i,
  input logic             trig_sel_i,
  input logic [LINES-1:0] trig_rdata_o
);
  AST_IDLE_ACK_NO_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_o) |=> !vec_valid_o); // R11
  AST_ACK_GIVES_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o) |=> vec_valid_o); // R12
  AST_VEC_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(ack_i)); // R12
  AST_VEC_BASE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> ((vec_o[VEC_W-1:IW] == $past(mst_base_i[VEC_W-1:IW])) ||
                     (vec_o[VEC_W-1:IW] == $past(slv_base_i[VEC_W-1:IW])))); // R8
  AST_MST_RD_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_sel_i |-> ((trig_rdata_o & ~MST_TRIG_MASK) == '0)); // R9
  AST_SLV_RD_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_sel_i |-> ((trig_rdata_o & ~SLV_TRIG_MASK) == '0)); // R9
  AST_CASC_BIT_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_sel_i |-> !trig_rdata_o[CASC_LINE]); // R9
endmodule

bind casc_int_ack casc_int_ack_chk #(
  .LINES(LINES), .VEC_W(VEC_W), .CASC_LINE(CASC_LINE),
  .MST_TRIG_MASK(MST_TRIG_MASK), .SLV_TRIG_MASK(SLV_TRIG_MASK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .int_o(int_o),
  .vec_valid_o(vec_valid_o), .vec_o(vec_o), .mst_base_i(mst_base_i),
  .slv_base_i(slv_base_i), .trig_sel_i(trig_sel_i), .trig_rdata_o(trig_rdata_o)
);

// File: tb/casc_int_ack_test.sv
module casc_int_ack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        ack = 1'b0, aeoi = 1'b0, rot_aeoi = 1'b0;
  logic [7:0]  mbase = 8'h20, sbase = 8'h70;
  logic        twe = 1'b0, tsel = 1'b0;
  logic [7:0]  twd = '0;
  logic [7:0]  trd;
  logic        int_l, vvalid;
  logic [7:0]  vec;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  casc_int_ack uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .ack_i(ack), .aeoi_i(aeoi),
    .rot_aeoi_i(rot_aeoi), .mst_base_i(mbase), .slv_base_i(sbase),
    .trig_we_i(twe), .trig_sel_i(tsel), .trig_wdata_i(twd),
    .trig_rdata_o(trd), .int_o(int_l), .vec_o(vec), .vec_valid_o(vvalid)
  );

  // ---------------- reference model ----------------
  bit [15:0] m_s1, m_s2, m_prev;
  bit [7:0]  m_irr [2];
  bit [7:0]  m_isr [2];
  bit [7:0]  m_trg [2];
  int        m_rot [2];
  bit        e_valid;
  bit [7:0]  e_vec;

  function automatic int best(bit [7:0] mask, int r);
    for (int k = 0; k < 8; k++) if (mask[(r + k) % 8]) return k;
    return 8;
  endfunction

  function automatic int winner(int u, bit casc);
    bit [7:0] eff = m_irr[u];
    int pr, cur;
    if (u == 0) eff[2] = casc;
    pr = best(eff, m_rot[u]);
    if (pr == 8) return -1;
    cur = best(m_isr[u], m_rot[u]);
    return (pr < cur) ? (pr + m_rot[u]) % 8 : -1;
  endfunction

  function automatic int mst_win();
    return winner(0, winner(1, 1'b0) >= 0);
  endfunction

  task automatic model_ack(int u, int l);
    if (!m_trg[u][l]) m_irr[u][l] = 1'b0;
    if (!aeoi) m_isr[u][l] = 1'b1;
    else if (rot_aeoi) m_rot[u] = (l + 1) % 8;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0;
      foreach (m_irr[u]) begin
        m_irr[u] = '0; m_isr[u] = '0; m_rot[u] = 0;
      end
      m_trg[0] = 8'h04; m_trg[1] = 8'h00;
      e_valid = 1'b0; e_vec = '0;
    end else begin
      int sw, mw;
      sw = winner(1, 1'b0);
      mw = winner(0, sw >= 0);
      e_valid = 1'b0;
      if (ack && mw >= 0) begin
        e_valid = 1'b1;
        model_ack(0, mw);
        if (mw == 2) begin
          model_ack(1, sw);
          e_vec = (sbase & 8'hF8) | 8'(sw);
        end else e_vec = (mbase & 8'hF8) | 8'(mw);
      end
      for (int i = 0; i < 16; i++) begin
        if (i != 2) begin
          if (m_s2[i] && !m_prev[i]) m_irr[i/8][i%8] = 1'b1;
          if (!m_s2[i] && m_prev[i]) m_irr[i/8][i%8] = 1'b0;
        end
      end
      if (twe) begin
        if (tsel) m_trg[1] = twd & 8'hDE;
        else m_trg[0] = (twd & 8'hF8) | 8'h04;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = irq;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cycles++;
      check("R3 model int_o", int_l, mst_win() >= 0);
      check("R12 model vec_valid_o", vvalid, e_valid);
      if (e_valid) check("R8 model vec_o", vec, e_vec);
      check("R9 model trig_rdata_o", trd, tsel ? (m_trg[1] & 8'hDE) : (m_trg[0] & 8'hF8));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    irq = '0; ack = 1'b0; twe = 1'b0; tsel = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    tick(2); rst_n = 1'b1; tick(1);
  endtask

  task automatic acknowledge();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  task automatic trig_write(bit sel, bit [7:0] d);
    tsel = sel; twd = d; twe = 1'b1; tick(1); twe = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 int_o", int_l, 0);
    check("R1 vec_valid_o", vvalid, 0);
    tsel = 1'b0; tick(1); check("R1 master trig read", trd, 8'h00);
    tsel = 1'b1; tick(1); check("R1 slave trig read", trd, 8'h00);
    tsel = 1'b0;

    // R2 rising/falling edges through synchroniser
    irq[5] = 1'b1; tick(2); check("R2 not yet visible", int_l, 0);
    tick(1); check("R2 rise sets request", int_l, 1);
    irq[5] = 1'b0; tick(3); check("R2 fall clears request", int_l, 0);

    // R3 R8 R11 R12 fixed priority, edge clear, vector form
    do_reset(); aeoi = 1'b1; rot_aeoi = 1'b0;
    irq[3] = 1'b1; irq[6] = 1'b1; tick(3);
    acknowledge(); check("R3 line 3 first", vec, 8'h23); check("R12 valid", vvalid, 1);
    tick(1); check("R12 single pulse", vvalid, 0);
    acknowledge(); check("R8 line 6 vector", vec, 8'h26);
    check("R4 edge lines cleared", int_l, 0);
    acknowledge(); check("R11 idle ack no valid", vvalid, 0);

    // R4 level trigger persists, R9 readback
    do_reset(); aeoi = 1'b1;
    trig_write(1'b0, 8'h08); check("R9 master read level bit", trd, 8'h08);
    irq[3] = 1'b1; tick(3);
    acknowledge(); check("R4 level vec", vec, 8'h23);
    check("R4 level request kept", int_l, 1);
    acknowledge(); check("R4 level repeats", vec, 8'h23);
    irq[3] = 1'b0; tick(3); check("R2 level fall clears", int_l, 0);

    // R5 in-service blocking
    do_reset(); aeoi = 1'b0;
    irq[4] = 1'b1; tick(3);
    acknowledge(); check("R5 vec line 4", vec, 8'h24);
    check("R5 in-service blocks self", int_l, 0);
    irq[6] = 1'b1; tick(3); check("R5 lower blocked", int_l, 0);
    irq[1] = 1'b1; tick(3); check("R5 higher passes", int_l, 1);
    acknowledge(); check("R5 vec line 1", vec, 8'h21);

    // R6 rotate on auto-EOI
    do_reset(); aeoi = 1'b1; rot_aeoi = 1'b1;
    irq[1] = 1'b1; irq[5] = 1'b1; tick(3);
    acknowledge(); check("R6 first line 1", vec, 8'h21);
    irq[0] = 1'b1; tick(3);
    acknowledge(); check("R6 rotated, 5 beats 0", vec, 8'h25);
    acknowledge(); check("R6 then line 0", vec, 8'h20);
    rot_aeoi = 1'b0;

    // R7 cascade through master line 2
    do_reset(); aeoi = 1'b1;
    irq[9] = 1'b1; irq[12] = 1'b1; tick(3);
    check("R7 slave raises int_o", int_l, 1);
    acknowledge(); check("R7 slave line 1", vec, 8'h71);
    acknowledge(); check("R7 slave line 4", vec, 8'h74);
    check("R7 slave drained", int_l, 0);
    irq[0] = 1'b1; irq[13] = 1'b1; tick(3);
    acknowledge(); check("R7 master 0 beats cascade", vec, 8'h20);
    acknowledge(); check("R8 slave base vector", vec, 8'h75);

    // R9 masks, R10 raw line 2
    do_reset(); aeoi = 1'b1;
    trig_write(1'b0, 8'hFF); check("R9 master masked read", trd, 8'hF8);
    trig_write(1'b1, 8'hFF); check("R9 slave masked read", trd, 8'hDE);
    irq[8] = 1'b1; tick(3);
    acknowledge(); check("R9 slave line 0 vec", vec, 8'h70);
    check("R9 slave line 0 stays edge", int_l, 0);
    tsel = 1'b0;
    irq[2] = 1'b1; tick(4); check("R10 raw line 2 ignored", int_l, 0);
    acknowledge(); check("R10 no vector from line 2", vvalid, 0);
    irq[2] = 1'b0; tick(4); check("R10 fall ignored", int_l, 0);

    tick(2);
    finish_run();
  end
endmodule